// File: doc/BRIEF.md
# Serial Audio Port with Stream Position Status

This block moves audio samples between a host and a serial audio line in I2S framing. In transmit mode it takes one sample at a time from a single data register, shifts it out MSB first and signals when the register can be refilled. In receive mode it assembles a sample from the serial line, places it in the same register and signals that it can be read. A frame holds a parameterized number of channel slots. Each slot holds a parameterized number of system words, and each system word carries one sample.

The bit clock either comes from outside on `sck_i` (follower) or is produced by dividing a reference input by a power of two (driver). In both cases `sck_o` carries the bit clock that the shift engine uses. Both clock inputs are sampled in the system clock domain, so each must be much slower than `clk_i`.

A missed refill in transmit raises a sticky underflow flag. An unread sample in receive raises a sticky overflow flag. The live channel and system-word counters let software find the next slot the engine will serve, then skip or pad samples to realign with the stream. Clearing the enable lets the current frame finish and then parks the engine with all counters at zero.

Top module: `serial_audio_port`

## Requirements
- R1: With `sck_dir_i`=1 the bit clock period is N periods of `ref_clk_i`. The `div_sel_i` codes are 0→1, 1→2, 2→4, 3→8 and 4→16; codes 5, 6 and 7 give divide-by-1.
- R2: With `sck_dir_i`=0 the bit clock follows `sck_i`, and `sck_o` reproduces it after a fixed synchronizer delay.
- R3: The engine updates `sd_o` and `ws_o` only after a falling bit-clock edge. Data goes out MSB first. `ws_o` is 0 during channel 0 and toggles on the falling edge that starts the last bit of each channel slot. Receive data is sampled on rising bit-clock edges.
- R4: Words are served in this order: channel 0 word 0, channel 0 word 1 … then the next channel. Each slot holds SYS_WORDS words of WORD_W bits.
- R5: `chan_o` and `swno_o` give the channel and the system word currently on the line. `chan_o` is always below CHANNELS.
- R6: In transmit mode, `wr_i` stores `wdata_i` and sets `full_o`, and the engine loading a word clears `full_o`. In transmit mode `dreq_o` = `dmen_i` & `en_i` & !`full_o`.
- R7: When a transmit word starts and `full_o` is 0, `udf_o` is set and the previous register contents are sent again.
- R8: In receive mode, a completed word appears on `rdata_o` with `full_o` set, and `rd_i` clears `full_o`. In receive mode `dreq_o` = `dmen_i` & `en_i` & `full_o`.
- R9: When a received word completes while `full_o` is 1 and `rd_i` is low, `ovf_o` is set and the new word replaces the old one.
- R10: `udf_o` and `ovf_o` hold until a clear strobe (`udf_clr_i`, `ovf_clr_i`). A new event in the same cycle takes priority over the clear. `irq_o` is the OR of both flags.
- R11: After `en_i` is cleared, the current frame completes. The engine then idles with `chan_o`=0, `swno_o`=0, `ws_o`=0 and `sd_o`=0, and it loads no further words.
- R12: After reset all outputs except `sck_o` are 0, and `sck_o` follows the selected clock source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| en_i | input | 1 | engine enable |
| dmen_i | input | 1 | enables transfer requests |
| tx_i | input | 1 | 1 transmit, 0 receive |
| sck_dir_i | input | 1 | 1 drive bit clock from reference, 0 follow `sck_i` |
| div_sel_i | input | 3 | reference division code |
| ref_clk_i | input | 1 | reference clock for driver mode |
| sck_i | input | 1 | external bit clock |
| sck_o | output | 1 | bit clock in use |
| ws_o | output | 1 | word select |
| sd_i | input | 1 | serial receive data |
| sd_o | output | 1 | serial transmit data |
| wr_i | input | 1 | data register write strobe |
| wdata_i | input | WORD_W | write data |
| rd_i | input | 1 | data register read strobe |
| rdata_o | output | WORD_W | data register contents |
| full_o | output | 1 | data register holds an unconsumed word |
| chan_o | output | 2 | current channel |
| swno_o | output | 1 | current system word in the slot |
| udf_o | output | 1 | sticky underflow flag |
| ovf_o | output | 1 | sticky overflow flag |
| udf_clr_i | input | 1 | clear strobe for `udf_o` |
| ovf_clr_i | input | 1 | clear strobe for `ovf_o` |
| dreq_o | output | 1 | transfer request |
| irq_o | output | 1 | error interrupt |

## Verification
The hardest case to reach is the realignment scenario: an error has to fall at a known stream position, and the words around it must still be accounted for. In transmit, the stimulus deliberately withholds exactly one refill in the middle of the second frame. The scoreboard then expects the repeated word at that slot. In receive, the reader is held off across two word completions. This produces an overflow at a known channel and system word and shows that the newer word replaced the older one. Enable is dropped in the middle of a frame to show that the last two words still leave the port before it parks.

// File: rtl/sap_pkg.sv
package sap_pkg;
  localparam int DIV_W = 4;

  // division code -> log2 of ratio; unused codes map to divide-by-1
  function automatic logic [2:0] div_shift(input logic [2:0] sel);
    return (sel <= 3'd4) ? sel : 3'd0;
  endfunction
endpackage

// File: rtl/sap_sync.sv
module sap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/sap_bclk_gen.sv
module sap_bclk_gen
  import sap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       master_i,
  input  logic [2:0] div_sel_i,
  input  logic       ref_i,
  input  logic       sck_i,
  output logic       bclk_o,
  output logic       rise_o,
  output logic       fall_o
);
  logic             ref_d;
  logic [DIV_W-1:0] cnt_q;
  logic             bclk_q, bclk_d;
  logic [2:0]       k;
  logic             src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_d  <= 1'b0;
      cnt_q  <= '0;
      bclk_q <= 1'b0;
      bclk_d <= 1'b0;
    end else begin
      ref_d  <= ref_i;
      if (ref_i && !ref_d) cnt_q <= cnt_q + 1'b1;
      bclk_q <= master_i ? src : sck_i;
      bclk_d <= bclk_q;
    end
  end

  // counter bit k-1 has a period of 2^k reference periods
  always_comb begin
    k   = div_shift(div_sel_i);
    src = (k == 3'd0) ? ref_i : cnt_q[2'(k - 3'd1)];
  end

  assign bclk_o = bclk_q;
  assign rise_o = bclk_q & ~bclk_d;
  assign fall_o = ~bclk_q & bclk_d;
endmodule

// File: rtl/sap_engine.sv
module sap_engine #(
  parameter int WORD_W    = 8,
  parameter int CHANNELS  = 2,
  parameter int SYS_WORDS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              en_i,
  input  logic              tx_i,
  input  logic              sd_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              sd_o,
  output logic              ws_o,
  output logic              busy_o,
  output logic [1:0]        ch_o,
  output logic              sw_o,
  output logic              load_o,
  output logic              rx_done_o,
  output logic [WORD_W-1:0] rx_word_o
);
  localparam int              BW      = $clog2(WORD_W);
  localparam logic [1:0]      CH_LAST = 2'(CHANNELS - 1);
  localparam logic            SW_LAST = 1'(SYS_WORDS - 1);
  localparam logic [BW-1:0]   BIT_TOP = BW'(WORD_W - 1);

  logic              busy_q, sd_q, ws_q, sw_q;
  logic [1:0]        ch_q;
  logic [BW-1:0]     bit_q;
  logic [WORD_W-1:0] sh_q;
  logic word_end, frame_end, start, adv, stop, step;

  always_comb begin
    word_end  = (bit_q == '0);
    frame_end = word_end && (ch_q == CH_LAST) && (sw_q == SW_LAST);
    start     = fall_i & ~busy_q & en_i;
    adv       = fall_i & busy_q & word_end & ~(frame_end & ~en_i);
    stop      = fall_i & busy_q & frame_end & ~en_i;
    step      = fall_i & busy_q & ~word_end;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sd_q   <= 1'b0;
      ws_q   <= 1'b0;
      sw_q   <= 1'b0;
      ch_q   <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
        ch_q   <= '0;
        sw_q   <= 1'b0;
        bit_q  <= BIT_TOP;
        ws_q   <= 1'b0;
      end
      if (adv) begin
        bit_q <= BIT_TOP;
        if (sw_q == SW_LAST) begin
          sw_q <= 1'b0;
          ch_q <= (ch_q == CH_LAST) ? 2'd0 : ch_q + 2'd1;
        end else begin
          sw_q <= 1'b1;
        end
      end
      if (start || adv) begin
        sd_q <= tx_i & tx_word_i[WORD_W-1];
        if (tx_i) sh_q <= {tx_word_i[WORD_W-2:0], 1'b0};
      end
      if (step) begin
        bit_q <= bit_q - 1'b1;
        if (tx_i) begin
          sd_q <= sh_q[WORD_W-1];
          sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        end
        // last bit of a slot: word select leads the next slot by one bit
        if (bit_q == BW'(1) && sw_q == SW_LAST) ws_q <= ~ws_q;
      end
      if (stop) begin
        busy_q <= 1'b0;
        ch_q   <= '0;
        sw_q   <= 1'b0;
        bit_q  <= '0;
        sd_q   <= 1'b0;
        ws_q   <= 1'b0;
      end
      if (rise_i && busy_q && !tx_i) sh_q <= {sh_q[WORD_W-2:0], sd_i};
    end
  end

  assign load_o    = start | adv;
  assign rx_done_o = rise_i & busy_q & ~tx_i & word_end;
  assign rx_word_o = {sh_q[WORD_W-2:0], sd_i};
  assign sd_o      = sd_q;
  assign ws_o      = ws_q;
  assign busy_o    = busy_q;
  assign ch_o      = ch_q;
  assign sw_o      = sw_q;
endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port #(
  parameter int WORD_W      = 8,
  parameter int CHANNELS    = 2,
  parameter int SYS_WORDS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              dmen_i,
  input  logic              tx_i,
  input  logic              sck_dir_i,
  input  logic [2:0]        div_sel_i,
  input  logic              ref_clk_i,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              ws_o,
  input  logic              sd_i,
  output logic              sd_o,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              full_o,
  output logic [1:0]        chan_o,
  output logic              swno_o,
  output logic              udf_o,
  output logic              ovf_o,
  input  logic              udf_clr_i,
  input  logic              ovf_clr_i,
  output logic              dreq_o,
  output logic              irq_o
);
  logic ref_s, sck_s, rise, fall, busy, load, rx_done;
  logic [WORD_W-1:0] rx_word, dreg_q;
  logic full_q, udf_q, ovf_q;

  sap_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ref_clk_i), .q_o(ref_s));
  sap_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sck_i), .q_o(sck_s));

  sap_bclk_gen u_bclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .master_i(sck_dir_i), .div_sel_i(div_sel_i),
    .ref_i(ref_s), .sck_i(sck_s), .bclk_o(sck_o), .rise_o(rise), .fall_o(fall));

  sap_engine #(.WORD_W(WORD_W), .CHANNELS(CHANNELS), .SYS_WORDS(SYS_WORDS)) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .fall_i(fall), .en_i(en_i),
    .tx_i(tx_i), .sd_i(sd_i), .tx_word_i(dreg_q), .sd_o(sd_o), .ws_o(ws_o),
    .busy_o(busy), .ch_o(chan_o), .sw_o(swno_o), .load_o(load),
    .rx_done_o(rx_done), .rx_word_o(rx_word));

  // clears first, then sets, so a same-cycle event wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dreg_q <= '0;
      full_q <= 1'b0;
      udf_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (udf_clr_i) udf_q <= 1'b0;
      if (ovf_clr_i) ovf_q <= 1'b0;
      if (load && tx_i) begin
        full_q <= 1'b0;
        if (!full_q) udf_q <= 1'b1;
      end
      if (rd_i && !tx_i) full_q <= 1'b0;
      if (rx_done) begin
        dreg_q <= rx_word;
        full_q <= 1'b1;
        if (full_q && !rd_i) ovf_q <= 1'b1;
      end
      if (wr_i && tx_i) begin
        dreg_q <= wdata_i;
        full_q <= 1'b1;
      end
    end
  end

  assign rdata_o = dreg_q;
  assign full_o  = full_q;
  assign udf_o   = udf_q;
  assign ovf_o   = ovf_q;
  assign irq_o   = udf_q | ovf_q;
  assign dreq_o  = dmen_i & en_i & (tx_i ? ~full_q : full_q);
endmodule

// File: rtl/sap_chk.sv
module sap_chk #(
  parameter int CHANNELS = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sck_o,
  input logic       ws_o,
  input logic       sd_o,
  input logic [1:0] chan_o,
  input logic       swno_o,
  input logic       udf_o,
  input logic       ovf_o,
  input logic       udf_clr_i,
  input logic       ovf_clr_i,
  input logic       tx_i,
  input logic       busy_i
);
  a_r5_chan_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(chan_o) < CHANNELS);

  a_r11_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (chan_o == 2'd0) && !swno_o && !ws_o && !sd_o);

  a_r3_change_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(sck_o) |=> $stable(ws_o) && $stable(sd_o));

  a_r10_udf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_o && !udf_clr_i |=> udf_o);

  a_r10_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !ovf_clr_i |=> ovf_o);

  a_r7_udf_tx_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(udf_o) |-> $past(tx_i));

  a_r9_ovf_rx_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> !$past(tx_i));
endmodule

bind serial_audio_port sap_chk #(.CHANNELS(CHANNELS)) u_sap_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sck_o(sck_o), .ws_o(ws_o), .sd_o(sd_o),
  .chan_o(chan_o), .swno_o(swno_o), .udf_o(udf_o), .ovf_o(ovf_o),
  .udf_clr_i(udf_clr_i), .ovf_clr_i(ovf_clr_i), .tx_i(tx_i), .busy_i(busy));

// File: tb/tb_serial_audio_port.sv
module tb_serial_audio_port;
  localparam int W  = 8;
  localparam int CH = 2;
  localparam int SW = 2;

  typedef struct packed {
    logic [W-1:0] data;
    logic [1:0]   ch;
    logic         sw;
  } item_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en_i = 0, dmen_i = 0, tx_i = 0, sck_dir_i = 0, ref_clk_i = 0, sck_i = 0, sd_i = 0;
  logic [2:0] div_sel_i = 3'd0;
  logic wr_i = 0, rd_i = 0, udf_clr_i = 0, ovf_clr_i = 0;
  logic [W-1:0] wdata_i = '0;
  logic sck_o, ws_o, sd_o, full_o, swno_o, udf_o, ovf_o, dreq_o, irq_o;
  logic [W-1:0] rdata_o;
  logic [1:0] chan_o;

  int n_chk = 0, n_err = 0;
  bit done = 0, hold_rd = 0, rx_stop = 0;
  item_t exp_q[$];

  always #2 clk = ~clk;

  initial forever begin
    repeat (2) @(negedge clk);
    ref_clk_i <= ~ref_clk_i;
  end

  serial_audio_port #(.WORD_W(W), .CHANNELS(CH), .SYS_WORDS(SW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .dmen_i(dmen_i), .tx_i(tx_i),
    .sck_dir_i(sck_dir_i), .div_sel_i(div_sel_i), .ref_clk_i(ref_clk_i),
    .sck_i(sck_i), .sck_o(sck_o), .ws_o(ws_o), .sd_i(sd_i), .sd_o(sd_o),
    .wr_i(wr_i), .wdata_i(wdata_i), .rd_i(rd_i), .rdata_o(rdata_o),
    .full_o(full_o), .chan_o(chan_o), .swno_o(swno_o), .udf_o(udf_o),
    .ovf_o(ovf_o), .udf_clr_i(udf_clr_i), .ovf_clr_i(ovf_clr_i),
    .dreq_o(dreq_o), .irq_o(irq_o));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] val(input int s);
    return W'((s * 113 + 37) ^ (s << 3));
  endfunction

  function automatic item_t mk(input int s, input logic [W-1:0] d);
    item_t it;
    it.data = d;
    it.ch   = 2'((s / SW) % CH);
    it.sw   = 1'(s % SW);
    return it;
  endfunction

  task automatic wait_sck(input logic lvl);
    logic p;
    p = sck_o;
    forever begin
      @(negedge clk);
      if (sck_o == lvl && p != lvl) break;
      p = sck_o;
    end
  endtask

  task automatic host_write(input logic [W-1:0] d);
    wr_i = 1'b1; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic measure(input logic [2:0] code, input int ratio);
    int cyc;
    div_sel_i = code;
    wait_sck(1); wait_sck(1);
    cyc = 0;
    begin
      logic p;
      p = sck_o;
      forever begin
        @(negedge clk);
        cyc++;
        if (sck_o && !p) break;
        p = sck_o;
      end
    end
    chk(cyc == 4 * ratio, $sformatf("R1 period code %0d", code), cyc, 4 * ratio);
  endtask

  task automatic tx_monitor(input int nwords);
    wait_sck(0);
    for (int w = 0; w < nwords; w++) begin
      logic [W-1:0] got;
      item_t e;
      e = (exp_q.size() > 0) ? exp_q[0] : '0;
      got = '0;
      for (int b = 0; b < W; b++) begin
        wait_sck(1);
        got = {got[W-2:0], sd_o};
        if (b == 0)
          chk(ws_o == e.ch[0], "R3 ws at MSB", ws_o, e.ch[0]);
        if (b == W - 1 && e.sw == 1'(SW - 1))
          chk(ws_o == ~e.ch[0], "R3 ws leads next slot", ws_o, ~e.ch[0]);
        if (b == W / 2)
          chk(chan_o == e.ch && swno_o == e.sw, "R5 tx position",
              {chan_o, swno_o}, {e.ch, e.sw});
      end
      if (exp_q.size() == 0) chk(0, "R4 scoreboard empty", got, 0);
      else begin
        e = exp_q.pop_front();
        chk(got == e.data, $sformatf("R4 tx word %0d", w), got, e.data);
      end
    end
  endtask

  task automatic tx_driver();
    for (int s = 1; s < 12; s++) begin
      if (s == 6) continue;
      if (s == 7) begin
        while (!udf_o) @(negedge clk);
        chk(irq_o == 1'b1, "R10 irq on underflow", irq_o, 1);
        udf_clr_i = 1'b1; @(negedge clk); udf_clr_i = 1'b0;
        @(negedge clk);
        chk(udf_o == 1'b0, "R10 underflow clear", udf_o, 0);
      end else begin
        while (!dreq_o) @(negedge clk);
      end
      host_write(val(s));
      exp_q.push_back(mk(s, val(s)));
      if (s == 1) chk(full_o && !dreq_o, "R6 full after write", {full_o, dreq_o}, 2'b10);
      // R7: word 6 is never written, so word 5 must be resent
      if (s == 5) exp_q.push_back(mk(6, val(5)));
    end
    chk(chan_o == 2'd1, "R11 still mid-frame at disable", chan_o, 1);
    en_i = 1'b0;
  endtask

  task automatic rx_driver();
    for (int s = 0; s < 8; s++) begin
      logic [W-1:0] d;
      d = val(s + 20);
      exp_q.push_back(mk(s, d));
      if (s == 4) hold_rd = 1;
      for (int b = 0; b < W; b++) begin
        sck_i = 1'b0; sd_i = d[W-1-b];
        repeat (6) @(negedge clk);
        sck_i = 1'b1;
        repeat (6) @(negedge clk);
        if (b == W / 2 && s < 4)
          chk(chan_o == 2'((s / SW) % CH) && swno_o == 1'(s % SW), "R5 rx position",
              {chan_o, swno_o}, {2'((s / SW) % CH), 1'(s % SW)});
        if (b == 1 && s == 0) chk(sck_o == 1'b1, "R2 sck_o follows sck_i", sck_o, 1);
      end
      if (s == 5) begin
        chk(ovf_o == 1'b1, "R9 overflow set", ovf_o, 1);
        chk(rdata_o == d, "R9 newest word kept", rdata_o, d);
        chk(dreq_o == 1'b1 && irq_o == 1'b1, "R8 dreq/irq when full", {dreq_o, irq_o}, 2'b11);
        void'(exp_q.pop_front());
        hold_rd = 0;
        ovf_clr_i = 1'b1; @(negedge clk); ovf_clr_i = 1'b0;
        @(negedge clk);
        chk(ovf_o == 1'b0, "R10 overflow clear", ovf_o, 0);
      end
    end
    en_i = 1'b0;
    sck_i = 1'b0; sd_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(chan_o == 2'd0 && swno_o == 1'b0, "R11 rx idle after frame", {chan_o, swno_o}, 0);
    rx_stop = 1;
  endtask

  task automatic rx_reader();
    while (!rx_stop) begin
      @(negedge clk);
      if (full_o && !hold_rd && exp_q.size() > 0) begin
        item_t e;
        e = exp_q.pop_front();
        chk(rdata_o == e.data, "R8 rx word", rdata_o, e.data);
        rd_i = 1'b1; @(negedge clk); rd_i = 1'b0;
        @(negedge clk);
        chk(full_o == 1'b0, "R8 read clears full", full_o, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk({chan_o, swno_o, ws_o, sd_o} == 0, "R12 reset position/line", {chan_o, swno_o, ws_o, sd_o}, 0);
    chk({udf_o, ovf_o, irq_o, full_o, dreq_o} == 0, "R12 reset flags",
        {udf_o, ovf_o, irq_o, full_o, dreq_o}, 0);

    sck_dir_i = 1'b1;
    measure(3'd0, 1);
    measure(3'd2, 4);
    measure(3'd4, 16);
    measure(3'd7, 1);

    div_sel_i = 3'd1; tx_i = 1'b1; dmen_i = 1'b1;
    repeat (40) @(negedge clk);
    host_write(val(0));
    exp_q.push_back(mk(0, val(0)));
    chk(dreq_o == 1'b0, "R6 no request while disabled", dreq_o, 0);
    en_i = 1'b1;
    fork
      tx_monitor(12);
      tx_driver();
    join
    repeat (40) @(negedge clk);
    chk({chan_o, swno_o, sd_o, ws_o} == 0, "R11 tx idle after frame", {chan_o, swno_o, sd_o, ws_o}, 0);
    chk(udf_o == 1'b0, "R11 no load after stop", udf_o, 0);

    tx_i = 1'b0; sck_dir_i = 1'b0; sck_i = 1'b1;
    exp_q.delete();
    repeat (10) @(negedge clk);
    en_i = 1'b1;
    @(negedge clk);
    fork
      rx_driver();
      rx_reader();
    join

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule